// File: doc/BRIEF.md
# Frequency / Period Measurement Counter

This block measures a signal picked from one of two inputs, a fast input and a slow input, and reports the result as a binary count. It runs in one of two ways. In frequency mode it counts rising edges of the chosen input while a gate window is open. The window is built from whole ticks of a reference time base. In period mode it waits for a rising edge of the slow input. It then counts system clock cycles across one or two full input periods. The result is the length of those periods in reference clock cycles.

Three configuration bits control a measurement. The first picks the input. The second picks the mode, and it only matters for the slow input, because the fast input always measures frequency. The third doubles the measurement, giving either twice the gate ticks or twice the number of periods. A 0-to-1 transition on the enable pin captures these bits, clears the result and starts one measurement. The block then raises a done flag when the window closes and holds the result until the next start.

States: `S_IDLE` (after reset, nothing running), `S_ARM` (period mode, waiting for the opening edge), `S_MEASURE` (window open, counting), `S_DONE` (result frozen). Transitions:
- start: any state → `S_ARM` in period mode, or → `S_MEASURE` in frequency mode.
- open: `S_ARM` → `S_MEASURE` on a rising edge of the selected input.
- gate_close: `S_MEASURE` → `S_DONE` in frequency mode, on the tick that ends the gate.
- period_close: `S_MEASURE` → `S_DONE` in period mode, on the rising edge that ends the last period.

Any state other than these stays where it is.

Top module: `fpc_counter`

## Requirements
- R1: The result is a 20-bit binary count (parameter CNT_W, default 20). After reset, count is 0, done is 0 and busy is 0.
- R2: A measurement starts only on a 0-to-1 transition of enable. The clock edge that sees the transition clears count to 0 and drops done, and busy is 1 from the next cycle on. Keeping enable high does not start another measurement.
- R3: With sel_high=1, the block measures frequency on high_in whatever freq_mode says. It counts rising edges of high_in (high now, low in the previous cycle), and low_in has no effect.
- R4: With sel_high=0 and freq_mode=1, the block counts rising edges of low_in in frequency mode.
- R5: In frequency mode the window covers every cycle from the cycle after the start up to and including the cycle with the N-th ref_tick pulse. N is GATE_TICKS when gate_long=0 and 2*GATE_TICKS when gate_long=1. An edge in the closing cycle is counted.
- R6: With sel_high=0 and freq_mode=0 (period mode), the block waits for a rising edge of low_in. It then counts clock cycles until the next rising edge (gate_long=0) or the second one (gate_long=1). With a steady input period of P cycles the result is P or 2P.
- R7: When the window closes, done goes to 1 and busy to 0 in the same cycle. Count and done then hold until the next start.
- R8: The count saturates at all-ones (2^CNT_W-1) and never wraps.
- R9: sel_high, freq_mode and gate_long are captured at the start. Changing them while a measurement is running does not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System and reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Start request, acts on its rising transition |
| sel_high | input | 1 | 1 = fast input, 0 = slow input |
| freq_mode | input | 1 | Slow input only: 1 = frequency, 0 = period |
| gate_long | input | 1 | 1 = double gate ticks or double period count |
| ref_tick | input | 1 | One-cycle pulse of the reference time base |
| high_in | input | 1 | Fast measured input, synchronous to clk |
| low_in | input | 1 | Slow measured input, synchronous to clk |
| count | output | CNT_W | Measurement result |
| done | output | 1 | Measurement finished, result valid |
| busy | output | 1 | Measurement armed or running |

## Verification
Frequency mode is driven with square waves on the fast input while the slow input toggles at a different rate. This shows whether the correct input is counted and whether the mode bit is really overridden. Frequency mode on the slow input with the long gate shows that the gate length follows the tick count: the bench counts the tick pulses that fall inside busy. Period mode uses steady slow waveforms with one and two periods, and the result must equal the period in cycles. Configuration changes in mid-measurement, a held enable, and a narrow counter that overflows separate capture, retrigger and saturation faults. A behavioural model is compared on every clock.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_ARM     = 2'd1,
        S_MEASURE = 2'd2,
        S_DONE    = 2'd3
    } fpc_state_t;
endpackage

// File: rtl/fpc_edge.sv
module fpc_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] rise
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= sig[i];
        end
        assign rise[i] = sig[i] & ~prev_q;
    end
endmodule

// File: rtl/fpc_gate.sv
module fpc_gate #(
    parameter int GATE_TICKS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    input  logic long_sel,
    output logic expire
);
    localparam int MAXT = 2 * GATE_TICKS;
    localparam int TW   = $clog2(MAXT + 1);

    logic [TW-1:0] ticks_q;
    logic [TW-1:0] target;

    assign target = long_sel ? TW'(MAXT) : TW'(GATE_TICKS);
    assign expire = run && tick && (ticks_q == target - TW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            ticks_q <= '0;
        else if (clr)          ticks_q <= '0;
        else if (run && tick)  ticks_q <= ticks_q + TW'(1);
    end

    // R5
    gate_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ticks_q <= target);
endmodule

// File: rtl/fpc_acc.sv
module fpc_acc #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] value
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        value <= '0;
        else if (clr)                      value <= '0;
        else if (inc && value != ALL_ONES) value <= value + CNT_W'(1);
    end

    // R8
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (value == ALL_ONES && !clr) |=> value == ALL_ONES);
endmodule

// File: rtl/fpc_counter.sv
module fpc_counter
    import fpc_pkg::*;
#(
    parameter int CNT_W      = 20,
    parameter int GATE_TICKS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sel_high,
    input  logic             freq_mode,
    input  logic             gate_long,
    input  logic             ref_tick,
    input  logic             high_in,
    input  logic             low_in,
    output logic [CNT_W-1:0] count,
    output logic             done,
    output logic             busy
);
    fpc_state_t state_q, state_d;
    logic       en_q, start;
    logic       cfg_high, cfg_period, cfg_long, per_seen;
    logic [1:0] rise;
    logic       sel_edge, expire, acc_inc, gate_run, new_period;

    assign start      = enable & ~en_q;
    assign new_period = ~sel_high & ~freq_mode;

    fpc_edge #(.N(2)) u_edge (
        .clk(clk), .rst_n(rst_n), .sig({high_in, low_in}), .rise(rise)
    );
    assign sel_edge = cfg_high ? rise[1] : rise[0];

    assign gate_run = (state_q == S_MEASURE) && !cfg_period && !start;
    fpc_gate #(.GATE_TICKS(GATE_TICKS)) u_gate (
        .clk(clk), .rst_n(rst_n), .clr(start), .run(gate_run),
        .tick(ref_tick), .long_sel(cfg_long), .expire(expire)
    );

    assign acc_inc = (state_q == S_MEASURE) && (cfg_period || sel_edge);
    fpc_acc #(.CNT_W(CNT_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(start), .inc(acc_inc), .value(count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            cfg_high   <= 1'b0;
            cfg_period <= 1'b0;
            cfg_long   <= 1'b0;
            per_seen   <= 1'b0;
        end else begin
            en_q <= enable;
            if (start) begin
                cfg_high   <= sel_high;
                cfg_period <= new_period;
                cfg_long   <= gate_long;
                per_seen   <= 1'b0;
            end else if (state_q == S_MEASURE && cfg_period && sel_edge) begin
                per_seen <= 1'b1;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = new_period ? S_ARM : S_MEASURE;
        end else begin
            unique case (state_q)
                S_IDLE:  state_d = S_IDLE;
                S_ARM:   if (sel_edge) state_d = S_MEASURE;
                S_MEASURE: begin
                    if (cfg_period) begin
                        if (sel_edge && (!cfg_long || per_seen)) state_d = S_DONE;
                    end else if (expire) begin
                        state_d = S_DONE;
                    end
                end
                S_DONE:  state_d = S_DONE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        done = 1'b0;
        busy = 1'b0;
        unique case (state_q)
            S_IDLE:    ;
            S_ARM:     busy = 1'b1;
            S_MEASURE: busy = 1'b1;
            S_DONE:    done = 1'b1;
        endcase
    end

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count == '0 && !done && busy));
    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(count)));
    // R7
    done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));
    // R8
    monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start) |=> count >= $past(count));
endmodule

// File: tb/fpc_counter_test.sv
module fpc_counter_test;
    localparam int W  = 20;
    localparam int GT = 6;
    localparam int TP = 10;
    localparam int MAXC = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 0, sel_high = 0, freq_mode = 0, gate_long = 0;
    logic ref_tick = 0, high_in = 0, low_in = 0;
    logic [W-1:0] count;
    logic [4:0] count_s;
    logic done, busy, done_s, busy_s;

    int checks = 0, fails = 0, cyc = 0, hhalf = 0, lhalf = 0;
    string cur_req = "R1";

    // model state: 0 idle, 1 arm, 2 measure, 3 done
    int m_st = 0, m_cnt = 0, m_ticks = 0;
    bit m_per_seen = 0, m_hi = 0, m_per = 0, m_long = 0;
    bit ph = 0, pl = 0, pen = 0;

    always #5 clk = ~clk;

    fpc_counter #(.CNT_W(W), .GATE_TICKS(GT)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sel_high(sel_high),
        .freq_mode(freq_mode), .gate_long(gate_long), .ref_tick(ref_tick),
        .high_in(high_in), .low_in(low_in), .count(count), .done(done), .busy(busy));

    fpc_counter #(.CNT_W(5), .GATE_TICKS(GT)) sat_uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sel_high(sel_high),
        .freq_mode(freq_mode), .gate_long(gate_long), .ref_tick(ref_tick),
        .high_in(high_in), .low_in(low_in), .count(count_s), .done(done_s), .busy(busy_s));

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_update();
        bit eh, el, st, se;
        int target;
        eh = high_in && !ph;
        el = low_in && !pl;
        st = enable && !pen;
        se = m_hi ? eh : el;
        target = m_long ? 2 * GT : GT;
        if (st) begin
            m_cnt = 0; m_ticks = 0; m_per_seen = 0;
            m_hi = sel_high; m_per = !sel_high && !freq_mode; m_long = gate_long;
            m_st = m_per ? 1 : 2;
        end else if (m_st == 1) begin
            if (se) m_st = 2;
        end else if (m_st == 2) begin
            if (m_per) begin
                if (m_cnt < MAXC) m_cnt++;
                if (se) begin
                    if (!m_long || m_per_seen) m_st = 3;
                    else m_per_seen = 1;
                end
            end else begin
                if (se && m_cnt < MAXC) m_cnt++;
                if (ref_tick) begin
                    if (m_ticks == target - 1) m_st = 3;
                    m_ticks++;
                end
            end
        end
        ph = high_in; pl = low_in; pen = enable;
    endtask

    task automatic step();
        cyc++;
        high_in  = (hhalf > 0) ? ((cyc / hhalf) % 2 == 1) : 1'b0;
        low_in   = (lhalf > 0) ? ((cyc / lhalf) % 2 == 1) : 1'b0;
        ref_tick = (cyc % TP == TP - 1);
        model_update();
        @(posedge clk);
        @(negedge clk);
        check(cur_req, int'(count), m_cnt);
        check(cur_req, {31'd0, done}, (m_st == 3) ? 1 : 0);
        check(cur_req, {31'd0, busy}, (m_st == 1 || m_st == 2) ? 1 : 0);
    endtask

    task automatic start_meas(bit sh, bit fm, bit gl);
        enable = 0; step();
        enable = 1; sel_high = sh; freq_mode = fm; gate_long = gl; step();
    endtask

    task automatic wait_done(output int ticks_in);
        ticks_in = 0;
        for (int i = 0; i < 2000 && !done; i++) begin
            bit was_busy;
            was_busy = busy;
            step();
            if (was_busy && cyc % TP == TP - 1) ticks_in++;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int tk;
        @(negedge clk);
        // R1 reset state
        check("R1", int'(count), 0);
        check("R1", {31'd0, done}, 0);
        check("R1", {31'd0, busy}, 0);
        check("R1", $bits(count), 20);
        rst_n = 1;
        step();

        // R3: fast input, mode bit says period but is overridden
        cur_req = "R3"; hhalf = 2; lhalf = 3;
        start_meas(1, 0, 0);
        wait_done(tk);
        check("R3", {31'd0, done}, 1);
        check("R5", tk, GT);
        check("R3", (count >= 12 && count <= 15) ? 1 : 0, 1);

        // R7: result held, enable held high (R2 no retrigger)
        cur_req = "R7";
        begin
            logic [W-1:0] held;
            held = count;
            for (int i = 0; i < 40; i++) step();
            check("R7", int'(count), int'(held));
            check("R2", {31'd0, done}, 1);
        end

        // R4 + R5 long gate on slow input
        cur_req = "R4"; hhalf = 1; lhalf = 5;
        start_meas(0, 1, 1);
        wait_done(tk);
        check("R5", tk, 2 * GT);
        check("R4", (count >= 10 && count <= 12) ? 1 : 0, 1);

        // R6 period mode, one and two periods
        cur_req = "R6"; hhalf = 3; lhalf = 10;
        start_meas(0, 0, 0);
        wait_done(tk);
        check("R6", int'(count), 20);
        start_meas(0, 0, 1);
        wait_done(tk);
        check("R6", int'(count), 40);

        // R9 config changed mid-measurement
        cur_req = "R9"; lhalf = 7;
        start_meas(0, 0, 0);
        for (int i = 0; i < 5; i++) step();
        sel_high = 1; freq_mode = 1; gate_long = 1;
        wait_done(tk);
        check("R9", int'(count), 14);

        // R8 saturation on a narrow counter
        cur_req = "R8"; lhalf = 20;
        start_meas(0, 0, 1);
        wait_done(tk);
        check("R8", int'(count), 80);
        check("R8", int'(count_s), 31);
        check("R8", {31'd0, done_s}, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule